// File: doc/BRIEF.md
# Segmented Instruction Prefetch Unit

This block keeps a small queue of instruction bytes ready ahead of the execution side of a 16-bit processor with a 20-bit byte address space. It holds a code segment value and a fetch offset, forms the physical fetch address by shifting the segment left four bits and adding the offset, and issues word reads on a request/response memory port. Bytes from each returned word are appended to a six-entry byte queue, and the consumer removes them one per cycle.

Only one read is outstanding at a time. A word read is issued only while at least two queue slots are free, so the unit runs ahead of the consumer and stops when the queue is full. An odd fetch address yields one byte (the upper half of the word); an even one yields two. A redirect loads a new segment and offset, empties the queue in the same cycle, and causes the data of any read already in flight to be dropped.

Top module: `pf_fetch_unit`

## Requirements
- R1: After reset the queue is empty (`q_empty` = 1) and the first read request carries address `RST_SEG`*16 + `RST_OFF`.
- R2: Every request address is (segment * 16 + offset) modulo 2^20, so segment 0xFFFF with offset 0x0010 gives address 0x00000.
- R3: Bytes leave the queue in ascending address order; in a returned word, bits 7:0 are the byte at the even address and bits 15:8 the byte at the odd address.
- R4: A read at an odd address queues only bits 15:8 of the word and advances the offset by 1; a read at an even address queues both bytes and advances the offset by 2.
- R5: The offset wraps modulo 2^16 and the segment value does not change (segment 0x0100, offset 0xFFFE is followed by offset 0x0000, address 0x01000).
- R6: A read is requested only when no read is outstanding and at least 2 of the 6 queue slots are free; with no pops, the unit keeps requesting until this no longer holds, and the queue never holds more than 6 bytes.
- R7: While a request is not accepted, `mem_req_valid` stays high and `mem_req_addr` stays unchanged, unless a redirect occurs.
- R8: A redirect empties the queue by the next cycle, loads the new segment and offset, and any response to a read accepted before it (including one arriving in the redirect cycle) is discarded.
- R9: A pop while the queue is empty has no effect: the queue stays empty and later bytes are delivered in order.
- R10: Whenever `q_empty` is 0, `q_byte` shows the oldest queued byte, and a pop removes exactly that byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| redir_valid | input | 1 | Load a new fetch segment/offset and flush |
| redir_seg | input | 16 | New code segment value |
| redir_off | input | 16 | New fetch offset |
| mem_req_valid | output | 1 | Word read request valid |
| mem_req_addr | output | 20 | Physical byte address of the request |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 16 | Word containing the requested byte |
| pop | input | 1 | Consumer removes the head byte |
| q_byte | output | 8 | Oldest byte in the queue |
| q_empty | output | 1 | Queue holds no bytes |

## Verification
The fetch stream is tried from an even start crossing the 2^16 offset boundary, from an odd start, and from a start just below the top of the 20-bit space; the first separates two-byte from one-byte fills and shows the segment is not carried into, the last shows the 20-bit wrap. Runs with the consumer stalled tell the two-free-slots rule apart from a plain full check, since an odd start leaves the queue one byte short of full until a single pop. Redirects are given while a response arrives in the same cycle and while it is still some cycles away, which distinguishes dropping a stale word from merely flushing the queue. Pops held against an empty queue with the memory stalled show that pops do not disturb the pointers.

// File: rtl/pf_pkg.sv
package pf_pkg;
    localparam int SEG_W = 16;
    localparam int OFF_W = 16;
    localparam int PA_W  = 20;
    localparam int BYTE_W = 8;

    typedef logic [SEG_W-1:0] seg_t;
    typedef logic [OFF_W-1:0] off_t;
    typedef logic [PA_W-1:0]  paddr_t;

    // Fetch-side control state
    typedef struct packed {
        seg_t seg;
        off_t off;
        logic busy;   // a read has been accepted and awaits its response
        logic drop;   // the awaited response belongs to a flushed stream
        logic odd;    // the awaited read was at an odd address
    } fetch_st_t;
endpackage

// File: rtl/pf_addr_gen.sv
module pf_addr_gen #(
    parameter int SW = 16,
    parameter int OW = 16,
    parameter int AW = 20
) (
    input  logic [SW-1:0] seg_i,
    input  logic [OW-1:0] off_i,
    output logic [AW-1:0] phys_o
);
    localparam int SHIFT = AW - SW;

    // Segment scaled by 16, offset zero-extended; carry out of AW is lost.
    always_comb begin
        phys_o = {seg_i, {SHIFT{1'b0}}} + {{(AW-OW){1'b0}}, off_i};
    end
endmodule

// File: rtl/pf_byte_queue.sv
module pf_byte_queue #(
    parameter int DEPTH = 6,
    parameter int BW    = 8,
    localparam int PW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush_i,
    input  logic [1:0]    push_n_i,
    input  logic [BW-1:0] push_b0_i,
    input  logic [BW-1:0] push_b1_i,
    input  logic          pop_i,
    output logic [BW-1:0] head_o,
    output logic          empty_o,
    output logic [CW-1:0] count_o
);
    typedef struct packed {
        logic [DEPTH-1:0][BW-1:0] mem;
        logic [PW-1:0]            rd;
        logic [PW-1:0]            wr;
        logic [CW-1:0]            cnt;
    } q_st_t;

    q_st_t q_d, q_q;
    logic          do_pop;
    logic [PW-1:0] wr_nx, wr_nx2, rd_nx;

    function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        wr_nx  = step(q_q.wr);
        wr_nx2 = step(wr_nx);
        rd_nx  = step(q_q.rd);
        do_pop = pop_i && (q_q.cnt != '0);
        q_d    = q_q;
        if (flush_i) begin
            q_d.rd  = '0;
            q_d.wr  = '0;
            q_d.cnt = '0;
        end else begin
            if (push_n_i != 2'd0) q_d.mem[q_q.wr] = push_b0_i;
            if (push_n_i == 2'd2) q_d.mem[wr_nx]  = push_b1_i;
            case (push_n_i)
                2'd1:    q_d.wr = wr_nx;
                2'd2:    q_d.wr = wr_nx2;
                default: q_d.wr = q_q.wr;
            endcase
            if (do_pop) q_d.rd = rd_nx;
            q_d.cnt = q_q.cnt + CW'(push_n_i) - CW'(do_pop);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q_q <= '0;
        else        q_q <= q_d;
    end

    assign head_o  = q_q.mem[q_q.rd];
    assign empty_o = (q_q.cnt == '0);
    assign count_o = q_q.cnt;

    // R6: the fetch side must never push past the capacity
    p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        q_q.cnt <= CW'(DEPTH));

    // R9: popping an empty queue with nothing arriving leaves it empty
    p_empty_pop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && empty_o && push_n_i == 2'd0 && !flush_i) |=> empty_o);
endmodule

// File: rtl/pf_fetch_unit.sv
module pf_fetch_unit
    import pf_pkg::*;
#(
    parameter int          QDEPTH  = 6,
    parameter logic [15:0] RST_SEG = 16'hFFFF,
    parameter logic [15:0] RST_OFF = 16'h0000,
    localparam int CW = $clog2(QDEPTH + 1)
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        redir_valid,
    input  logic [15:0] redir_seg,
    input  logic [15:0] redir_off,
    output logic        mem_req_valid,
    output logic [19:0] mem_req_addr,
    input  logic        mem_req_ready,
    input  logic        mem_rsp_valid,
    input  logic [15:0] mem_rsp_data,
    input  logic        pop,
    output logic [7:0]  q_byte,
    output logic        q_empty
);
    localparam logic [CW-1:0] FILL_LIM = CW'(QDEPTH - 2);

    fetch_st_t st_d, st_q;
    logic [CW-1:0]     q_count;
    logic              free_ok, accept, rsp_take;
    logic [1:0]        push_n;
    logic [BYTE_W-1:0] push_b0, push_b1;

    pf_addr_gen #(.SW(SEG_W), .OW(OFF_W), .AW(PA_W)) i_addr (
        .seg_i (st_q.seg),
        .off_i (st_q.off),
        .phys_o(mem_req_addr)
    );

    always_comb begin
        free_ok       = (q_count <= FILL_LIM);
        mem_req_valid = !st_q.busy && free_ok && !redir_valid;
        accept        = mem_req_valid && mem_req_ready;
        rsp_take      = mem_rsp_valid && st_q.busy;
        push_n        = (rsp_take && !st_q.drop && !redir_valid)
                        ? (st_q.odd ? 2'd1 : 2'd2) : 2'd0;
        push_b0       = st_q.odd ? mem_rsp_data[15:8] : mem_rsp_data[7:0];
        push_b1       = mem_rsp_data[15:8];

        st_d = st_q;
        if (redir_valid) begin
            st_d.seg  = redir_seg;
            st_d.off  = redir_off;
            st_d.busy = st_q.busy && !rsp_take;
            st_d.drop = st_q.busy && !rsp_take;
        end else begin
            if (rsp_take) begin
                st_d.busy = 1'b0;
                st_d.drop = 1'b0;
            end
            if (accept) begin
                st_d.busy = 1'b1;
                st_d.odd  = st_q.off[0];
                st_d.off  = st_q.off + (st_q.off[0] ? 16'd1 : 16'd2);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.seg  <= RST_SEG;
            st_q.off  <= RST_OFF;
        end else begin
            st_q <= st_d;
        end
    end

    pf_byte_queue #(.DEPTH(QDEPTH), .BW(BYTE_W)) i_queue (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush_i  (redir_valid),
        .push_n_i (push_n),
        .push_b0_i(push_b0),
        .push_b1_i(push_b1),
        .pop_i    (pop),
        .head_o   (q_byte),
        .empty_o  (q_empty),
        .count_o  (q_count)
    );

    // R8: a redirect leaves an empty queue behind it
    p_redir_flush_r8: assert property (@(posedge clk) disable iff (!rst_n)
        redir_valid |=> q_empty);

    // R7: an unaccepted request holds its address
    p_req_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=>
        (redir_valid || (mem_req_valid && $stable(mem_req_addr))));

    // R6: at most one read outstanding
    p_one_outstanding_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && mem_req_ready) |=> !mem_req_valid);

    // R5: advancing the offset never changes the segment
    p_seg_kept_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && mem_req_ready) |=> (st_q.seg == $past(st_q.seg)));
endmodule

// File: tb/test_pf_fetch_unit.sv
module test_pf_fetch_unit;
    localparam int CLK_PERIOD = 10;
    localparam logic [15:0] RSEG = 16'hFFFF;
    localparam logic [15:0] ROFF = 16'h0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        redir_valid = 1'b0;
    logic [15:0] redir_seg = '0, redir_off = '0;
    logic        mem_req_valid;
    logic [19:0] mem_req_addr;
    logic        mem_req_ready = 1'b0;
    logic        mem_rsp_valid = 1'b0;
    logic [15:0] mem_rsp_data = '0;
    logic        pop = 1'b0;
    logic [7:0]  q_byte;
    logic        q_empty;

    int n_tests = 0, n_fail = 0;
    logic [7:0]  exp_q[$];
    logic        pop_en = 1'b0, ready_en = 1'b0;
    int          lat = 2, cd = 0, pop_cnt = 0, acc_idx = 0;
    logic [19:0] pend_addr = '0;
    logic [19:0] acc_addr[16];

    pf_fetch_unit #(.RST_SEG(RSEG), .RST_OFF(ROFF)) i_pf_fetch_unit (
        .clk(clk), .rst_n(rst_n), .redir_valid(redir_valid),
        .redir_seg(redir_seg), .redir_off(redir_off),
        .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
        .mem_req_ready(mem_req_ready), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data(mem_rsp_data), .pop(pop), .q_byte(q_byte),
        .q_empty(q_empty)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [7:0] mbyte(input logic [19:0] a);
        return a[7:0] ^ {a[19:16], a[11:8]} ^ 8'h3C;
    endfunction

    function automatic logic [19:0] phys(input logic [15:0] s, input logic [15:0] o);
        return {s, 4'h0} + {4'h0, o};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Driver side of the scoreboard: expected byte stream from a start point
    task automatic exp_load(input logic [15:0] s, input logic [15:0] o, input int n);
        for (int i = 0; i < n; i++) exp_q.push_back(mbyte(phys(s, o + 16'(i))));
    endtask

    task automatic redirect(input logic [15:0] s, input logic [15:0] o);
        pop_en = 1'b0;
        @(negedge clk);
        redir_valid = 1'b1; redir_seg = s; redir_off = o;
        exp_q.delete();
        exp_load(s, o, 48);
        acc_idx = 0;
        @(negedge clk);
        redir_valid = 1'b0;
        check("R8 empty after redirect", q_empty, 1);
    endtask

    task automatic drain(input int k);
        int start = pop_cnt;
        int guard = 0;
        pop_en = 1'b1;
        while (pop_cnt < start + k && guard < 2000) begin
            @(negedge clk); guard++;
        end
        pop_en = 1'b0;
        if (guard >= 2000) check("R10 drain progress", 0, 1);
    endtask

    // Memory responder: accepts one read, answers lat cycles later
    initial begin
        forever begin
            @(negedge clk); #2;
            mem_rsp_valid = 1'b0;
            if (cd > 0) begin
                cd--;
                if (cd == 0) begin
                    mem_rsp_valid = 1'b1;
                    mem_rsp_data = {mbyte(pend_addr | 20'h1), mbyte(pend_addr & 20'hFFFFE)};
                end
            end
            mem_req_ready = ready_en;
            if (mem_req_valid && ready_en) begin
                pend_addr = mem_req_addr;
                cd = lat;
                if (acc_idx < 16) acc_addr[acc_idx] = mem_req_addr;
                acc_idx++;
            end
        end
    end

    // Monitor side of the scoreboard: pops and compares against the expectation
    initial begin
        forever begin
            @(negedge clk); #1;
            pop = pop_en;
            if (pop_en && !q_empty) begin
                if (exp_q.size() == 0) check("R10 unexpected byte", q_byte, 0);
                else check("R3 R10 byte order", q_byte, exp_q.pop_front());
                pop_cnt++;
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 150000);
        n_tests++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        exp_load(RSEG, ROFF, 48);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state and first address
        check("R1 empty at reset", q_empty, 1);
        check("R1 request after reset", mem_req_valid, 1);
        check("R1 reset address", mem_req_addr, 20'hFFFF0);
        @(negedge clk);
        // R7: unaccepted request is held
        check("R7 held valid", mem_req_valid, 1);
        check("R7 held address", mem_req_addr, 20'hFFFF0);
        // Stream across the 20-bit boundary from reset
        ready_en = 1'b1;
        drain(20);

        // R2: top-of-space wrap
        redirect(16'hFFFF, 16'h000E);
        repeat (12) @(negedge clk);
        check("R2 first address", acc_addr[0], 20'hFFFFE);
        check("R2 wrapped address", acc_addr[1], 20'h00000);
        drain(10);

        // R5 R6: even start, offset wrap, queue fills with no pops
        redirect(16'h0100, 16'hFFFE);
        repeat (30) @(negedge clk);
        check("R6 requests until full", acc_idx, 3);
        check("R5 offset FFFE address", acc_addr[0], 20'h10FFE);
        check("R5 offset wrapped, segment kept", acc_addr[1], 20'h01000);
        check("R4 even step of 2", acc_addr[2], 20'h01002);
        check("R6 no request when full", mem_req_valid, 0);
        drain(12);

        // R4 R6: odd start leaves 5 bytes, one pop frees two slots
        redirect(16'h1234, 16'h0101);
        repeat (30) @(negedge clk);
        check("R4 R6 stop with one slot free", acc_idx, 3);
        check("R4 odd step of 1", acc_addr[1], 20'h12442);
        check("R6 idle with 5 bytes", mem_req_valid, 0);
        pop_en = 1'b1;
        @(negedge clk);
        pop_en = 1'b0;
        repeat (10) @(negedge clk);
        check("R6 request after two slots free", acc_idx, 4);
        check("R6 idle when full again", mem_req_valid, 0);
        drain(10);

        // R8: redirect coinciding with the response
        lat = 2;
        redirect(16'h4000, 16'h0010);
        while (acc_idx < 1) @(negedge clk);
        redirect(16'h5A00, 16'h0020);
        drain(8);

        // R8: redirect while the response is still far away
        lat = 5;
        redirect(16'h6000, 16'h0040);
        while (acc_idx < 1) @(negedge clk);
        redirect(16'h7100, 16'h0031);
        drain(8);
        lat = 2;

        // R9: pops against an empty queue with memory stalled
        ready_en = 1'b0;
        redirect(16'h2000, 16'h0003);
        pop_en = 1'b1;
        repeat (5) @(negedge clk);
        pop_en = 1'b0;
        check("R9 still empty", q_empty, 1);
        check("R7 stalled address", mem_req_addr, 20'h20003);
        ready_en = 1'b1;
        drain(8);

        repeat (5) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule